// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves the control-transfer instructions of a 64-bit register-machine instruction set in one pipeline stage. Each cycle with `valid_i` high it takes the 8-bit opcode, the destination and source register values, the 32-bit immediate, the signed 16-bit slot offset and the byte address of the current instruction. One clock later it reports whether the branch is taken and which program counter comes next. It also reports whether the instruction asks the surrounding control logic to call a helper or to end the program, and whether the encoding is illegal.

Conditions are evaluated either on full-width operands or on the low 32 bits only. The unsigned and signed orderings are separate condition codes. A bit-test condition is taken when the two operands share a set bit. Instructions are 8-byte slots, so a taken branch lands at the following slot plus the offset scaled by eight. The unit does not run helper functions, hold registers or manage a stack. It only raises call and exit requests.

Top module: `branch_resolve`

## Requirements
- R1: While `rst_ni` is low, and until the first accepted instruction, `valid_o`, `taken_o`, `call_o`, `exit_o`, `illegal_o` and `next_pc_o` are all zero.
- R2: Results appear exactly one clock after the `valid_i` cycle that carried the instruction. `valid_o` follows `valid_i` with one cycle delay. All four flags are zero whenever `valid_o` is low.
- R3: Opcode bits [2:0] pick the class: value 5 compares full 64-bit operands and value 6 compares only bits [31:0] of both operands, ignoring the upper halves.
- R4: Opcode bit 3 set selects `src_val_i` as the second operand, and clear selects the immediate. In class 5 the immediate is sign-extended from bit 31 to 64 bits. In class 6 its 32 bits are used as they are.
- R5: Opcode bits [7:4] = 1 is taken on equality, 5 on inequality, and 4 when the bitwise AND of the operands is nonzero.
- R6: Unsigned codes: 2 greater, 3 greater-or-equal, 10 less, 11 less-or-equal.
- R7: Signed (two's complement) codes: 6 greater, 7 greater-or-equal, 12 less, 13 less-or-equal.
- R8: Code 0 in class 5 is always taken.
- R9: A taken branch gives `next_pc_o = pc_i + 8 + 8*sext(offset_i)`. Otherwise `next_pc_o = pc_i + 8`. Both wrap modulo 2^PC_W.
- R10: Code 8 in either class raises `call_o`, is not taken, and uses the sequential program counter.
- R11: Code 9 in class 5 raises `exit_o`, is not taken, and uses the sequential program counter.
- R12: Code 0 or 9 in class 6, codes 14 and 15, and any class other than 5 or 6 raise `illegal_o`. Such an instruction is not taken, raises no call or exit, and uses the sequential program counter.
- R13: At most one of `taken_o`, `call_o`, `exit_o`, `illegal_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 8 | Opcode: code [7:4], operand select [3], class [2:0] |
| dst_val_i | input | XLEN | Destination register value (first operand) |
| src_val_i | input | XLEN | Source register value |
| imm_i | input | 32 | Immediate value |
| offset_i | input | 16 | Signed branch offset in slots |
| pc_i | input | PC_W | Byte address of this instruction |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | PC_W | Address of the next instruction |
| call_o | output | 1 | Call request |
| exit_o | output | 1 | Exit request |
| illegal_o | output | 1 | Illegal branch-class encoding |

## Verification
The bench builds the unit at its defaults: XLEN = 64, PC_W = 32 and a slot shift of 3. With 64-bit operands, the class-6 lane can be fed values whose upper halves disagree with their lower halves, so narrow and wide results differ on the same inputs. The 32-bit program counter lets a short directed case cross the top of the address space and check the wrap of the sequential target. The same width also lets a negative offset land below the current address.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  localparam logic [3:0] CD_ALWAYS = 4'h0;
  localparam logic [3:0] CD_EQ     = 4'h1;
  localparam logic [3:0] CD_UGT    = 4'h2;
  localparam logic [3:0] CD_UGE    = 4'h3;
  localparam logic [3:0] CD_ANDNZ  = 4'h4;
  localparam logic [3:0] CD_NE     = 4'h5;
  localparam logic [3:0] CD_SGT    = 4'h6;
  localparam logic [3:0] CD_SGE    = 4'h7;
  localparam logic [3:0] CD_CALL   = 4'h8;
  localparam logic [3:0] CD_EXIT   = 4'h9;
  localparam logic [3:0] CD_ULT    = 4'ha;
  localparam logic [3:0] CD_ULE    = 4'hb;
  localparam logic [3:0] CD_SLT    = 4'hc;
  localparam logic [3:0] CD_SLE    = 4'hd;

  typedef struct packed {
    logic       wide;
    logic       use_reg;
    logic [3:0] code;
    logic       cond;
    logic       always_j;
    logic       call;
    logic       exit_req;
    logic       bad;
  } br_dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [7:0] opcode_i,
  output br_dec_t    dec_o
);
  logic [2:0] cls;
  assign cls = opcode_i[2:0];

  always_comb begin
    dec_o         = '0;
    dec_o.code    = opcode_i[7:4];
    dec_o.use_reg = opcode_i[3];
    dec_o.wide    = (cls == CLS_WIDE);
    if (cls != CLS_WIDE && cls != CLS_NARROW) begin
      dec_o.bad = 1'b1;
    end else begin
      unique case (opcode_i[7:4])
        CD_ALWAYS: begin
          dec_o.always_j = dec_o.wide;
          dec_o.bad      = !dec_o.wide;
        end
        CD_EXIT: begin
          dec_o.exit_req = dec_o.wide;
          dec_o.bad      = !dec_o.wide;
        end
        CD_CALL:      dec_o.call = 1'b1;
        4'he, 4'hf:   dec_o.bad  = 1'b1;
        default:      dec_o.cond = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            wide_i,
  input  logic [3:0]      code_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            hit_o
);
  localparam int HALF = XLEN / 2;

  // lane 0: low half, lane 1: full width
  logic [1:0] eq_l, ltu_l, lts_l, anyb_l;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 1) ? XLEN : HALF;
    logic [LW-1:0] x, y;
    assign x         = a_i[LW-1:0];
    assign y         = b_i[LW-1:0];
    assign eq_l[g]   = (x == y);
    assign ltu_l[g]  = (x < y);
    assign lts_l[g]  = ($signed(x) < $signed(y));
    assign anyb_l[g] = |(x & y);
  end

  logic eq, ltu, lts, anyb;
  assign eq   = wide_i ? eq_l[1]   : eq_l[0];
  assign ltu  = wide_i ? ltu_l[1]  : ltu_l[0];
  assign lts  = wide_i ? lts_l[1]  : lts_l[0];
  assign anyb = wide_i ? anyb_l[1] : anyb_l[0];

  always_comb begin
    unique case (code_i)
      CD_EQ:    hit_o = eq;
      CD_NE:    hit_o = !eq;
      CD_ANDNZ: hit_o = anyb;
      CD_UGT:   hit_o = !(ltu || eq);
      CD_UGE:   hit_o = !ltu;
      CD_ULT:   hit_o = ltu;
      CD_ULE:   hit_o = ltu || eq;
      CD_SGT:   hit_o = !(lts || eq);
      CD_SGE:   hit_o = !lts;
      CD_SLT:   hit_o = lts;
      CD_SLE:   hit_o = lts || eq;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int PC_W    = 32,
  parameter int OFF_W   = 16,
  parameter int SLOT_LG = 3
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             taken_i,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam logic [PC_W-1:0] SLOT = PC_W'(1) << SLOT_LG;

  logic [PC_W-1:0] seq_pc, off_ext, jmp_pc;
  assign seq_pc    = pc_i + SLOT;
  assign off_ext   = {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign jmp_pc    = seq_pc + (off_ext << SLOT_LG);
  assign next_pc_o = taken_i ? jmp_pc : seq_pc;
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import br_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int PC_W    = 32,
  parameter int SLOT_LG = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [7:0]      opcode_i,
  input  logic [XLEN-1:0] dst_val_i,
  input  logic [XLEN-1:0] src_val_i,
  input  logic [31:0]     imm_i,
  input  logic [15:0]     offset_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            valid_o,
  output logic            taken_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            call_o,
  output logic            exit_o,
  output logic            illegal_o
);
  localparam int IMM_W = 32;
  localparam int OFF_W = 16;
  localparam logic [PC_W-1:0] SLOT = PC_W'(1) << SLOT_LG;

  br_dec_t         dec;
  logic [XLEN-1:0] imm_ext, opnd_b;
  logic            hit, taken;
  logic [PC_W-1:0] npc;

  br_decode u_dec (.opcode_i(opcode_i), .dec_o(dec));

  assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign opnd_b  = dec.use_reg ? src_val_i : imm_ext;

  br_cond #(.XLEN(XLEN)) u_cond (
    .wide_i(dec.wide),
    .code_i(dec.code),
    .a_i   (dst_val_i),
    .b_i   (opnd_b),
    .hit_o (hit)
  );

  assign taken = dec.always_j || (dec.cond && hit);

  br_target #(.PC_W(PC_W), .OFF_W(OFF_W), .SLOT_LG(SLOT_LG)) u_tgt (
    .pc_i     (pc_i),
    .off_i    (offset_i),
    .taken_i  (taken),
    .next_pc_o(npc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      call_o    <= 1'b0;
      exit_o    <= 1'b0;
      illegal_o <= 1'b0;
      next_pc_o <= '0;
    end else begin
      valid_o   <= valid_i;
      taken_o   <= valid_i && taken;
      call_o    <= valid_i && dec.call;
      exit_o    <= valid_i && dec.exit_req;
      illegal_o <= valid_i && dec.bad;
      if (valid_i) next_pc_o <= npc;
    end
  end

  p_quiet_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(taken_o || call_o || exit_o || illegal_o));

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_one_flag_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({taken_o, call_o, exit_o, illegal_o}));

  p_seq_pc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7:4] == CD_CALL && opcode_i[2:0] == CLS_WIDE)
      |=> (next_pc_o == $past(pc_i) + SLOT));

  p_narrow_ja_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[2:0] == CLS_NARROW && opcode_i[7:4] == CD_ALWAYS)
      |=> (illegal_o && !taken_o));

  p_call_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[7:4] == CD_CALL && opcode_i[2:0] == CLS_NARROW) |=> call_o);
endmodule

// File: tb/branch_resolve_bench.sv
module branch_resolve_bench;
  localparam int XLEN = 64;
  localparam int PC_W = 32;

  typedef struct packed {
    logic [7:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [31:0] imm;
    logic [15:0] off;
    logic [31:0] pc;
    logic [3:0]  fl;  // {taken, call, exit, illegal}
    logic [7:0]  rq;
  } vec_t;

  localparam logic [3:0] T = 4'b1000, C = 4'b0100, X = 4'b0010, I = 4'b0001, N = 4'b0000;
  localparam logic [31:0] P = 32'h0000_1000;
  localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 29;

  localparam vec_t VECS [NV] = '{
    '{8'h1d, 64'd5, 64'd5, 32'd0, 16'd4, P, T, 8'd5},                      // R5 eq reg
    '{8'h1d, 64'd5, 64'd6, 32'd0, 16'd4, P, N, 8'd5},                      // R5
    '{8'h55, 64'd7, 64'd0, 32'd7, 16'd4, P, N, 8'd5},                      // R5 ne imm
    '{8'h4d, 64'hF0, 64'h0F, 32'd0, 16'd4, P, N, 8'd5},                    // R5 and zero
    '{8'h4d, 64'hF0, 64'h10, 32'd0, 16'h0010, P, T, 8'd5},                 // R5 and nonzero
    '{8'h2d, M1, 64'd1, 32'd0, 16'd2, P, T, 8'd6},                         // R6 ugt
    '{8'h6d, M1, 64'd1, 32'd0, 16'd2, P, N, 8'd7},                         // R7 sgt
    '{8'ha5, 64'd5, 64'd0, 32'hFFFF_FFFF, 16'd3, P, T, 8'd4},              // R4 sext imm
    '{8'h16, 64'hDEAD_0000_0000_0007, 64'd0, 32'd7, 16'd1, P, T, 8'd3},    // R3 narrow
    '{8'h15, 64'hDEAD_0000_0000_0007, 64'd0, 32'd7, 16'd1, P, N, 8'd4},    // R4 wide
    '{8'h3e, 64'h1_0000_0000, 64'd1, 32'd0, 16'd5, P, N, 8'd3},            // R3
    '{8'h3d, 64'h1_0000_0000, 64'd1, 32'd0, 16'd5, P, T, 8'd6},            // R6
    '{8'hbd, 64'd3, 64'd3, 32'd0, 16'd6, P, T, 8'd6},                      // R6 ule
    '{8'h7d, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 32'd0, 16'd7, P, T, 8'd7},
    '{8'hcd, 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 32'd0, 16'd8, P, T, 8'd7},    // R7 slt
    '{8'hdd, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, 32'd0, 16'd8, P, N, 8'd7},    // R7 sle
    '{8'hce, 64'h8000_0000, 64'd0, 32'd0, 16'd9, P, T, 8'd7},              // R7 narrow sign
    '{8'hcd, 64'h8000_0000, 64'd0, 32'd0, 16'd9, P, N, 8'd7},              // R7 wide
    '{8'h66, 64'h7FFF_FFFF, 64'd0, 32'h8000_0000, 16'd1, P, T, 8'd7},      // R7 narrow imm
    '{8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFE, P, T, 8'd8},                   // R8 back jump
    '{8'h85, 64'd0, 64'd0, 32'd0, 16'd4, P, C, 8'd10},                     // R10
    '{8'h95, 64'd0, 64'd0, 32'd0, 16'd4, P, X, 8'd11},                     // R11
    '{8'h06, 64'd0, 64'd0, 32'd0, 16'd4, P, I, 8'd12},                     // R12
    '{8'h96, 64'd0, 64'd0, 32'd0, 16'd4, P, I, 8'd12},                     // R12
    '{8'he5, 64'd0, 64'd0, 32'd0, 16'd4, P, I, 8'd12},                     // R12
    '{8'h07, 64'd0, 64'd0, 32'd0, 16'd4, P, I, 8'd12},                     // R12
    '{8'h86, 64'd0, 64'd0, 32'd0, 16'd4, P, C, 8'd10},                     // R10 narrow
    '{8'h25, 64'd2, 64'd0, 32'hFFFF_FFFF, 16'd4, P, N, 8'd4},              // R4 wide ugt
    '{8'ha6, 64'd2, 64'd0, 32'hFFFF_FFFF, 16'd4, P, T, 8'd4}               // R4 narrow ult
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [7:0]      opcode_i = '0;
  logic [XLEN-1:0] dst_val_i = '0, src_val_i = '0;
  logic [31:0]     imm_i = '0;
  logic [15:0]     offset_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic            valid_o, taken_o, call_o, exit_o, illegal_o;
  logic [PC_W-1:0] next_pc_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  branch_resolve u_branch_resolve (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .dst_val_i, .src_val_i, .imm_i,
    .offset_i, .pc_i, .valid_o, .taken_o, .next_pc_o, .call_o, .exit_o, .illegal_o
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pc(input logic [31:0] pc, input logic [15:0] off,
                                         input logic tk);
    logic [31:0] s;
    s = pc + 32'd8;
    return tk ? s + ({{16{off[15]}}, off} * 32'd8) : s;
  endfunction

  function automatic logic [3:0] flags();
    return {taken_o, call_o, exit_o, illegal_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid", 64'(valid_o), 64'd0);
    check("R1 flags", 64'(flags()), 64'd0);
    check("R1 pc", 64'(next_pc_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", 64'({valid_o, flags()}), 64'd0);

    for (int k = 0; k < NV; k++) begin
      valid_i   = 1'b1;
      opcode_i  = VECS[k].op;
      dst_val_i = VECS[k].a;
      src_val_i = VECS[k].b;
      imm_i     = VECS[k].imm;
      offset_i  = VECS[k].off;
      pc_i      = VECS[k].pc;
      @(negedge clk_i);
      checks++;
      if (flags() !== VECS[k].fl || valid_o !== 1'b1) begin
        errors++;
        $display("FAIL R%0d vec %0d flags actual=%b expected=%b", VECS[k].rq, k,
                 {valid_o, flags()}, {1'b1, VECS[k].fl});
      end
      check("R9 target", 64'(next_pc_o),
            64'(exp_pc(VECS[k].pc, VECS[k].off, VECS[k].fl[3])));
    end

    // R2: one-cycle latency and quiet idle
    valid_i  = 1'b0;
    opcode_i = 8'h05;
    @(negedge clk_i);
    check("R2 valid drops", 64'(valid_o), 64'd0);
    check("R2 flags idle", 64'(flags()), 64'd0);

    // R9: sequential address wraps at the top of the space
    valid_i  = 1'b1;
    opcode_i = 8'h1d;
    dst_val_i = 64'd1;
    src_val_i = 64'd2;
    pc_i     = 32'hFFFF_FFF8;
    @(negedge clk_i);
    check("R9 wrap", 64'(next_pc_o), 64'd0);
    // R9: taken with largest positive offset
    opcode_i = 8'h05;
    offset_i = 16'h7FFF;
    pc_i     = 32'h0000_0100;
    @(negedge clk_i);
    check("R9 max offset", 64'(next_pc_o), 64'h0004_0100);
    check("R8 taken", 64'(taken_o), 64'd1);
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 hold pc", 64'(next_pc_o), 64'h0004_0100);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule